// File: doc/BRIEF.md
# Configuration Command Register Engine

This block puts a small command processor behind three bus-visible registers: a data register, a command register and a status register. Software loads an operand into the data register if it needs one. It then writes a packed command word into the command register with the start bit set. In the same clock edge the engine splits the word into its fields, checks that the target exists, and performs the read or write against a fixed set of built-in functions.

The outcome lands in the status register one cycle after the start write. Bit 0 means done and bit 1 means failed. A successful read also leaves its result in the data register. The functions are a voltage read-back and four write actions: display routing, display mode, power-off and restart. Power-off and restart leave the block as single-cycle request pulses for the system controller.

A parameter removes the whole register set for variants that lack it. In that case all three offsets read as zero and no request pulses can be raised. The daughter-site voltage table and its length are parameters.

Top module: `cfg_cmd_engine`

## Requirements
- R1: After reset the data, command and status registers read zero and both request outputs are low.
- R2: The command register sits at offset 0xA4. Its layout is: bit 31 start, bit 30 direction (1 = write, 0 = read), bits 29:26 controller select, bits 25:20 function, bits 17:16 site, bits 15:12 stack position, bits 11:0 device. Bits 31, 19 and 18 are never stored and always read back as zero; all other bits read back as written.
- R3: The status register sits at offset 0xA8. Bit 0 means done and bit 1 means failed. A command write with start = 1 sets status to 1 (success) or 3 (failure), readable from the next cycle. A command write with start = 0 leaves status unchanged.
- R4: Any command with a nonzero controller select, a nonzero stack position, or site 2 or 3 fails.
- R5: A read of function 2 at site 0 succeeds only for device 0 and returns 3300000.
- R6: A read of function 2 at site 1 succeeds only when the device index is below the configured table length, and returns that table entry. Every other read function fails.
- R7: A successful read loads its result into the data register. A failed read leaves the data register unchanged, and so does any write command.
- R8: Write commands succeed only at site 0, device 0, and only for function 7, 8, 9 or 11. Every other write fails.
- R9: A successful write of function 8 raises `shutdown_req`, and of function 9 raises `reboot_req`. Each request is high for exactly the one cycle after the start write. No other command raises either request.
- R10: A software write to status stores only bits 1:0 of the written value.
- R11: With the register set disabled by parameter, offsets 0xA0, 0xA4 and 0xA8 read zero, writes have no effect, and no request is raised.
- R12: The data register at offset 0xA0 stores and returns all 32 written bits. Offsets that are not decoded read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Bus access strobe; a write happens when it and bus_we are high at a clock edge |
| bus_we | input | 1 | Write enable for the access |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| shutdown_req | output | 1 | One-cycle power-off request |
| reboot_req | output | 1 | One-cycle restart request |

## Verification
The bench builds one instance with the register set enabled and a five-entry daughter voltage table, and a second instance with the set disabled that shares the same bus. Because the table is short while the index logic spans eight slots, sweeping device indices up to and past the length exercises both the accept and the reject side of the length bound, including stored entries that must never be returned. The small field widths allow exhaustive sweeps: every function code is tried in both directions, and every combination of controller select, stack position and site is tried with a voltage read. The disabled instance is compared on every read against the all-zero expectation.

// File: rtl/cfgeng_pkg.sv
package cfgeng_pkg;

   localparam int unsigned WORD_W    = 32;
   localparam int unsigned MAX_VOLT  = 8;
   localparam int unsigned VIDX_W    = $clog2(MAX_VOLT);

   localparam logic [11:0] OFF_DATA  = 12'h0A0;
   localparam logic [11:0] OFF_CTRL  = 12'h0A4;
   localparam logic [11:0] OFF_STAT  = 12'h0A8;

   // bits never held in the command register: start and the two spare bits
   localparam logic [WORD_W-1:0] CTRL_DROP = 32'h800C_0000;

   typedef enum logic [5:0] {
      FN_VOLT  = 6'd2,
      FN_ROUTE = 6'd7,
      FN_OFF   = 6'd8,
      FN_RESTART = 6'd9,
      FN_DMODE = 6'd11
   } fn_e;

   typedef struct packed {
      logic        wr;
      logic [3:0]  ctl_sel;
      logic [5:0]  fn;
      logic [1:0]  site;
      logic [3:0]  pos;
      logic [11:0] dev;
   } req_t;

endpackage

// File: rtl/cfgeng_decode.sv
module cfgeng_decode
   import cfgeng_pkg::*;
(
   input  logic [WORD_W-1:0] word,
   output logic              start,
   output req_t              req,
   output logic [WORD_W-1:0] keep_word
);

   always_comb begin
      start       = word[31];
      req.wr      = word[30];
      req.ctl_sel = word[29:26];
      req.fn      = word[25:20];
      req.site    = word[17:16];
      req.pos     = word[15:12];
      req.dev     = word[11:0];
      keep_word   = word & ~CTRL_DROP;
   end

endmodule

// File: rtl/cfgeng_exec.sv
module cfgeng_exec
   import cfgeng_pkg::*;
#(
   parameter int unsigned            VOLT_COUNT   = 2,
   parameter logic [WORD_W-1:0]      MB_MICROVOLT = 32'd3300000,
   parameter logic [MAX_VOLT*WORD_W-1:0] VOLT_TABLE = '0
)(
   input  req_t              req,
   output logic              ok,
   output logic [WORD_W-1:0] rd_val,
   output logic              shut,
   output logic              boot
);

   logic [WORD_W-1:0] ent [MAX_VOLT];
   logic              target_ok;
   logic              rd_ok;
   logic              wr_ok;
   logic              at_base;
   logic              in_table;

   for (genvar g = 0; g < MAX_VOLT; g++) begin : g_ent
      assign ent[g] = VOLT_TABLE[g*WORD_W +: WORD_W];
   end

   always_comb begin
      target_ok = (req.ctl_sel == 4'd0) && (req.pos == 4'd0) && (req.site <= 2'd1);
      at_base   = (req.site == 2'd0) && (req.dev == 12'd0);
      in_table  = (req.site == 2'd1) && (32'(req.dev) < VOLT_COUNT);

      rd_ok  = 1'b0;
      rd_val = '0;
      if (req.fn == FN_VOLT) begin
         if (in_table) begin
            rd_ok  = 1'b1;
            rd_val = ent[req.dev[VIDX_W-1:0]];
         end else if (at_base) begin
            rd_ok  = 1'b1;
            rd_val = MB_MICROVOLT;
         end
      end

      wr_ok = at_base && ((req.fn == FN_ROUTE) || (req.fn == FN_OFF) ||
                          (req.fn == FN_RESTART) || (req.fn == FN_DMODE));

      ok   = target_ok && (req.wr ? wr_ok : rd_ok);
      shut = ok && req.wr && (req.fn == FN_OFF);
      boot = ok && req.wr && (req.fn == FN_RESTART);
   end

endmodule

// File: rtl/cfgeng_regs.sv
module cfgeng_regs
   import cfgeng_pkg::*;
#(
   parameter int unsigned ADDR_W = 12
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WORD_W-1:0] bus_wdata,
   input  logic              start,
   input  logic              is_write,
   input  logic [WORD_W-1:0] keep_word,
   input  logic              ok,
   input  logic [WORD_W-1:0] rd_val,
   input  logic              shut,
   input  logic              boot,
   output logic [WORD_W-1:0] dat_r,
   output logic [WORD_W-1:0] ctl_r,
   output logic [1:0]        sts_r,
   output logic              shutdown_req,
   output logic              reboot_req
);

   logic wr_any, hit_data, hit_ctrl, hit_stat;

   always_comb begin
      wr_any   = bus_req && bus_we;
      hit_data = wr_any && (bus_addr == ADDR_W'(OFF_DATA));
      hit_ctrl = wr_any && (bus_addr == ADDR_W'(OFF_CTRL));
      hit_stat = wr_any && (bus_addr == ADDR_W'(OFF_STAT));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dat_r        <= '0;
         ctl_r        <= '0;
         sts_r        <= '0;
         shutdown_req <= 1'b0;
         reboot_req   <= 1'b0;
      end else begin
         shutdown_req <= 1'b0;
         reboot_req   <= 1'b0;
         if (hit_data) dat_r <= bus_wdata;
         if (hit_stat) sts_r <= bus_wdata[1:0];
         if (hit_ctrl) begin
            ctl_r <= keep_word;
            if (start) begin
               sts_r        <= {~ok, 1'b1};
               shutdown_req <= shut;
               reboot_req   <= boot;
               if (!is_write && ok) dat_r <= rd_val;
            end
         end
      end
   end

endmodule

// File: rtl/cfg_cmd_engine.sv
module cfg_cmd_engine
   import cfgeng_pkg::*;
#(
   parameter bit                         ENABLE_CFG   = 1'b1,
   parameter int unsigned                ADDR_W       = 12,
   parameter int unsigned                VOLT_COUNT   = 2,
   parameter logic [WORD_W-1:0]          MB_MICROVOLT = 32'd3300000,
   parameter logic [MAX_VOLT*WORD_W-1:0] VOLT_TABLE   = '0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              shutdown_req,
   output logic              reboot_req
);

   if (ADDR_W < 8 || ADDR_W > 16) begin : g_bad_addr
      $error("cfg_cmd_engine: ADDR_W must be within 8..16");
   end
   if (VOLT_COUNT > MAX_VOLT) begin : g_bad_count
      $error("cfg_cmd_engine: VOLT_COUNT exceeds table capacity");
   end

   logic [WORD_W-1:0] dat_r;
   logic [WORD_W-1:0] ctl_r;
   logic [1:0]        sts_r;

   if (ENABLE_CFG) begin : g_on
      logic              start;
      req_t              req;
      logic [WORD_W-1:0] keep_word;
      logic              ok, shut, boot;
      logic [WORD_W-1:0] rd_val;

      cfgeng_decode u_dec (
         .word      (bus_wdata),
         .start     (start),
         .req       (req),
         .keep_word (keep_word)
      );

      cfgeng_exec #(
         .VOLT_COUNT   (VOLT_COUNT),
         .MB_MICROVOLT (MB_MICROVOLT),
         .VOLT_TABLE   (VOLT_TABLE)
      ) u_exec (
         .req    (req),
         .ok     (ok),
         .rd_val (rd_val),
         .shut   (shut),
         .boot   (boot)
      );

      cfgeng_regs #(.ADDR_W(ADDR_W)) u_regs (
         .clk          (clk),
         .rst_n        (rst_n),
         .bus_req      (bus_req),
         .bus_we       (bus_we),
         .bus_addr     (bus_addr),
         .bus_wdata    (bus_wdata),
         .start        (start),
         .is_write     (req.wr),
         .keep_word    (keep_word),
         .ok           (ok),
         .rd_val       (rd_val),
         .shut         (shut),
         .boot         (boot),
         .dat_r        (dat_r),
         .ctl_r        (ctl_r),
         .sts_r        (sts_r),
         .shutdown_req (shutdown_req),
         .reboot_req   (reboot_req)
      );
   end else begin : g_off
      assign dat_r        = '0;
      assign ctl_r        = '0;
      assign sts_r        = '0;
      assign shutdown_req = 1'b0;
      assign reboot_req   = 1'b0;
   end

   always_comb begin
      unique case (bus_addr)
         ADDR_W'(OFF_DATA): bus_rdata = dat_r;
         ADDR_W'(OFF_CTRL): bus_rdata = ctl_r;
         ADDR_W'(OFF_STAT): bus_rdata = {30'd0, sts_r};
         default:           bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/cfg_cmd_engine_chk.sv
module cfg_cmd_engine_chk
   import cfgeng_pkg::*;
#(
   parameter bit          ENABLE_CFG = 1'b1,
   parameter int unsigned ADDR_W     = 12
)(
   input logic              clk,
   input logic              rst_n,
   input logic              bus_req,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       bus_rdata,
   input logic [1:0]        sts_r,
   input logic              shutdown_req,
   input logic              reboot_req
);

   logic ctrl_wr, stat_wr;
   assign ctrl_wr = ENABLE_CFG && bus_req && bus_we && (bus_addr == ADDR_W'(OFF_CTRL));
   assign stat_wr = ENABLE_CFG && bus_req && bus_we && (bus_addr == ADDR_W'(OFF_STAT));

   assert_ctrl_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(OFF_CTRL)) |-> (bus_rdata[31] == 1'b0 && bus_rdata[19:18] == 2'b00));

   assert_done_after_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && bus_wdata[31]) |=> sts_r[0]);

   assert_idle_write_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && !bus_wdata[31]) |=> $stable(sts_r));

   assert_status_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
      stat_wr |=> (sts_r == $past(bus_wdata[1:0])));

   assert_shut_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown_req |=> !shutdown_req);

   assert_boot_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      reboot_req |=> !reboot_req);

   assert_req_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(shutdown_req && reboot_req));

   assert_shut_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(shutdown_req) |-> $past(ctrl_wr && bus_wdata[31:30] == 2'b11 && bus_wdata[25:20] == 6'd8));

   assert_boot_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(reboot_req) |-> $past(ctrl_wr && bus_wdata[31:30] == 2'b11 && bus_wdata[25:20] == 6'd9));

   assert_off_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !ENABLE_CFG |-> (bus_rdata == 32'd0 && !shutdown_req && !reboot_req));

endmodule

bind cfg_cmd_engine cfg_cmd_engine_chk #(
   .ENABLE_CFG (ENABLE_CFG),
   .ADDR_W     (ADDR_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_req      (bus_req),
   .bus_we       (bus_we),
   .bus_addr     (bus_addr),
   .bus_wdata    (bus_wdata),
   .bus_rdata    (bus_rdata),
   .sts_r        (sts_r),
   .shutdown_req (shutdown_req),
   .reboot_req   (reboot_req)
);

// File: tb/cfg_cmd_engine_bench.sv
module cfg_cmd_engine_bench;

   localparam int unsigned AW    = 12;
   localparam int unsigned NVOLT = 5;
   localparam logic [AW-1:0] A_DATA = 12'h0A0;
   localparam logic [AW-1:0] A_CTRL = 12'h0A4;
   localparam logic [AW-1:0] A_STAT = 12'h0A8;

   function automatic logic [31:0] tbl_ent(input int i);
      return 32'd1200000 + 32'(i) * 32'd50000;
   endfunction

   function automatic logic [255:0] mk_table();
      logic [255:0] t;
      for (int i = 0; i < 8; i++) t[i*32 +: 32] = tbl_ent(i);
      return t;
   endfunction

   localparam logic [255:0] TBL = mk_table();

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_req = 1'b0;
   logic          bus_we = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   rdata_on, rdata_off;
   logic          shut_on, boot_on, shut_off, boot_off;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   bit off_pulsed = 1'b0;
   logic seen_shut, seen_boot;

   always #5 clk = ~clk;

   cfg_cmd_engine #(
      .ENABLE_CFG (1'b1), .ADDR_W (AW), .VOLT_COUNT (NVOLT),
      .MB_MICROVOLT (32'd3300000), .VOLT_TABLE (TBL)
   ) u_cfg_cmd_engine (
      .clk (clk), .rst_n (rst_n), .bus_req (bus_req), .bus_we (bus_we),
      .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (rdata_on),
      .shutdown_req (shut_on), .reboot_req (boot_on)
   );

   cfg_cmd_engine #(
      .ENABLE_CFG (1'b0), .ADDR_W (AW), .VOLT_COUNT (NVOLT),
      .MB_MICROVOLT (32'd3300000), .VOLT_TABLE (TBL)
   ) u_cfg_cmd_engine_off (
      .clk (clk), .rst_n (rst_n), .bus_req (bus_req), .bus_we (bus_we),
      .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (rdata_off),
      .shutdown_req (shut_off), .reboot_req (boot_off)
   );

   always @(negedge clk) if (shut_off || boot_off) off_pulsed = 1'b1;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_req = 1'b0; bus_we = 1'b0;
      seen_shut = shut_on;
      seen_boot = boot_on;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = rdata_on;
      chk("R11 disabled variant reads zero", rdata_off, 32'd0);
   endtask

   function automatic logic [31:0] mk(input bit st, input bit w, input int dcc,
                                      input int fn, input int site, input int pos, input int dev);
      return {st, w, 4'(dcc), 6'(fn), 2'b00, 2'(site), 4'(pos), 12'(dev)};
   endfunction

   // issue a command with a known data preload, then compare status, data and pulses
   task automatic run_cmd(input string tag, input bit w, input int dcc, input int fn,
                          input int site, input int pos, input int dev,
                          input bit exp_ok, input logic [31:0] exp_val);
      logic [31:0] v;
      logic [31:0] pre;
      pre = 32'hA5A5_0000 | 32'(fn);
      wr(A_DATA, pre);
      wr(A_CTRL, mk(1'b1, w, dcc, fn, site, pos, dev));
      chk({tag, " R9 shutdown pulse"}, 32'(seen_shut), 32'(exp_ok && w && fn == 8));
      chk({tag, " R9 reboot pulse"},   32'(seen_boot), 32'(exp_ok && w && fn == 9));
      rd(A_STAT, v);
      chk({tag, " R3/R4 status"}, v, exp_ok ? 32'd1 : 32'd3);
      rd(A_DATA, v);
      chk({tag, " R7 data"}, v, (exp_ok && !w) ? exp_val : pre);
      @(negedge clk);
      chk({tag, " R9 pulse ends"}, 32'({shut_on, boot_on}), 32'd0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(A_DATA, v); chk("R1 data after reset", v, 32'd0);
      rd(A_CTRL, v); chk("R1 ctrl after reset", v, 32'd0);
      rd(A_STAT, v); chk("R1 status after reset", v, 32'd0);
      chk("R1 requests low", 32'({shut_on, boot_on}), 32'd0);

      // R12 data register and undecoded offsets
      wr(A_DATA, 32'hDEAD_BEEF); rd(A_DATA, v); chk("R12 data readback", v, 32'hDEAD_BEEF);
      wr(A_DATA, 32'h1234_5678); rd(A_DATA, v); chk("R12 data readback", v, 32'h1234_5678);
      wr(12'h0AC, 32'hFFFF_FFFF); rd(12'h0AC, v); chk("R12 undecoded reads zero", v, 32'd0);
      rd(A_DATA, v); chk("R12 undecoded write ignored", v, 32'h1234_5678);

      // R2 / R3 command readback, start bit absent
      wr(A_CTRL, 32'h7FFF_FFFF); rd(A_CTRL, v); chk("R2 ctrl readback", v, 32'h7FF3_FFFF);
      rd(A_STAT, v); chk("R3 no start keeps status", v, 32'd0);
      wr(A_CTRL, 32'hFFFF_FFFF); rd(A_CTRL, v); chk("R2 start not stored", v, 32'h7FF3_FFFF);
      rd(A_STAT, v); chk("R3 failed start status", v, 32'd3);
      wr(A_CTRL, 32'h0012_3456); rd(A_STAT, v); chk("R3 no start keeps error", v, 32'd3);
      rd(A_CTRL, v); chk("R2 ctrl readback", v, 32'h0012_3456);

      // R10 status write keeps two bits
      wr(A_STAT, 32'hFFFF_FFFC); rd(A_STAT, v); chk("R10 status low bits", v, 32'd0);
      wr(A_STAT, 32'h8000_0006); rd(A_STAT, v); chk("R10 status low bits", v, 32'd2);
      wr(A_STAT, 32'h0000_0001); rd(A_STAT, v); chk("R10 status low bits", v, 32'd1);

      // R5/R6/R8 every function in both directions at site 0 device 0
      for (int fn = 0; fn < 64; fn++) begin
         run_cmd("R5/R6 read sweep", 1'b0, 0, fn, 0, 0, 0, fn == 2, 32'd3300000);
         run_cmd("R8 write sweep", 1'b1, 0, fn, 0, 0, 0,
                 fn == 7 || fn == 8 || fn == 9 || fn == 11, 32'd0);
      end

      // R4 every target combination with a voltage read of device 0
      for (int dcc = 0; dcc < 16; dcc++)
         for (int pos = 0; pos < 16; pos++)
            for (int site = 0; site < 4; site++)
               run_cmd("R4 target sweep", 1'b0, dcc, 2, site, pos, 0,
                       dcc == 0 && pos == 0 && site < 2,
                       (site == 1) ? tbl_ent(0) : 32'd3300000);

      // R6 daughter table bounds and R5 base device bounds
      for (int dev = 0; dev < 16; dev++) begin
         run_cmd("R6 table index", 1'b0, 0, 2, 1, 0, dev, dev < NVOLT,
                 (dev < 8) ? tbl_ent(dev) : 32'd0);
         run_cmd("R5 base device", 1'b0, 0, 2, 0, 0, dev, dev == 0, 32'd3300000);
      end
      run_cmd("R6 high index", 1'b0, 0, 2, 1, 0, 12'h801, 1'b0, 32'd0);

      // R8/R9 power actions only at site 0 device 0
      for (int site = 0; site < 4; site++)
         for (int dev = 0; dev < 3; dev++) begin
            run_cmd("R9 shutdown target", 1'b1, 0, 8, site, 0, dev, site == 0 && dev == 0, 32'd0);
            run_cmd("R9 reboot target",   1'b1, 0, 9, site, 0, dev, site == 0 && dev == 0, 32'd0);
            run_cmd("R8 route target",    1'b1, 0, 7, site, 0, dev, site == 0 && dev == 0, 32'd0);
            run_cmd("R8 mode target",     1'b1, 0, 11, site, 0, dev, site == 0 && dev == 0, 32'd0);
         end
      run_cmd("R9 shutdown bad select", 1'b1, 3, 8, 0, 0, 0, 1'b0, 32'd0);
      run_cmd("R9 reboot bad position", 1'b1, 0, 9, 0, 2, 0, 1'b0, 32'd0);

      // R11 disabled instance never requested anything
      chk("R11 disabled variant no requests", 32'(off_pulsed), 32'd0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule